// File: doc/BRIEF.md
# I2C Frame Position Guard

This block watches the SDA and SCL lines beside an I2C controller and flags a misplaced START or STOP condition. A misplaced condition is one that lands inside a byte or during its acknowledge bit. A flag is raised only while the controller reports that it is taking part in the transfer, either as the active master or as an addressed slave. On a flag the block performs the abort in hardware. It pulses a one-cycle error strobe that sends the controller back to the not-addressed-slave state, asks the controller to stop driving both lines, sets an interrupt and loads status code 00h.

The lines are sampled through a two-stage synchronizer. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The frame position is the number of SCL clocks completed since the last condition or frame boundary. That count is 0 at a frame boundary, 1 to 8 after each completed address or data bit, and 8 during the acknowledge clock. It wraps back to 0 when the acknowledge clock ends. A falling SCL edge counts only if it ends a clock that rose after the last condition, so the SCL fall that follows a START is not counted. Every START or STOP clears the count, so a START seen while the controller is not involved still realigns the count for address reception.

The interrupt, the line release request and the 00h status stay in place until the host pulses the clear input. Clearing sets the status back to F8h.

Top module: `i2c_frame_guard`

## Requirements
- R1: After reset, bus_error, irq and release_lines are 0, status is F8h and bit_pos is 0.
- R2: A START (SDA 1 to 0 while SCL stays high) while involved is 1 and bit_pos is between 1 and 8 is a bus error.
- R3: A STOP (SDA 0 to 1 while SCL stays high) while involved is 1 and bit_pos is between 1 and 8 is a bus error.
- R4: A START or STOP during the high phase of the acknowledge clock (bit_pos equal to 8) is a bus error.
- R5: A START or STOP while bit_pos is 0 is not an error, whether before the first bit of a frame or after the acknowledge clock has ended.
- R6: While involved is 0, a START or STOP raises no error, and it still returns bit_pos to 0.
- R7: On a bus error, bus_error is high for exactly one clock, and release_lines and irq go to 1 and status to 00h. All of this is visible within 4 clocks of the offending line change.
- R8: irq, release_lines and status 00h hold until irq_clear is sampled high. One clock later irq and release_lines are 0 and status is F8h.
- R9: bit_pos increments at the falling SCL edge of each completed clock, returns to 0 after the ninth clock, and is cleared by every START or STOP.
- R10: SDA changes while SCL is low never produce an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| involved | input | 1 | Controller is active master or addressed slave |
| irq_clear | input | 1 | Host clears the interrupt (one-clock pulse) |
| bus_error | output | 1 | One-clock strobe: abort to not-addressed-slave state |
| release_lines | output | 1 | Controller must stop driving SDA and SCL |
| irq | output | 1 | Interrupt flag |
| status | output | 8 | Status code: 00h after bus error, F8h otherwise |
| bit_pos | output | 4 | Completed SCL clocks in the current frame |

## Verification
The in-module assertions check four rules on every cycle. An error strobe happens only when the controller was involved and the position was nonzero. The strobe lasts one clock and arrives together with irq, release and status 00h. Status holds only 00h or F8h, and the position never leaves its range. Only the bench scenarios can show that a real condition on the lines is recognised at each illegal position, including the acknowledge clock, and that legal boundaries and uninvolved traffic pass silently. The same holds for the hold-until-clear behaviour and the clearing of the count by a START seen while not involved.

// File: rtl/i2c_frame_guard.sv
module i2c_frame_guard #(
  parameter int          FRAME_BITS = 9,
  parameter logic [7:0]  IDLE_CODE  = 8'hF8,
  parameter logic [7:0]  ERR_CODE   = 8'h00,
  localparam int         CW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          involved,
  input  logic          irq_clear,
  output logic          bus_error,
  output logic          release_lines,
  output logic          irq,
  output logic [7:0]    status,
  output logic [CW-1:0] bit_pos
);

  localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);

  logic [1:0] scl_sync, sda_sync;
  logic       scl_d, sda_d, in_clock;

  wire scl_q    = scl_sync[1];
  wire sda_q    = sda_sync[1];
  wire scl_high = scl_q & scl_d;
  wire start_c  = scl_high & sda_d & ~sda_q;
  wire stop_c   = scl_high & ~sda_d & sda_q;
  wire cond     = start_c | stop_c;
  wire scl_rise = scl_q & ~scl_d;
  wire scl_fall = ~scl_q & scl_d;
  wire err      = cond & involved & (bit_pos != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_d    <= scl_q;
      sda_d    <= sda_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos  <= '0;
      in_clock <= 1'b0;
    end else if (cond) begin
      bit_pos  <= '0;
      in_clock <= 1'b0;
    end else if (scl_rise) begin
      in_clock <= 1'b1;
    end else if (scl_fall && in_clock) begin
      in_clock <= 1'b0;
      bit_pos  <= (bit_pos == LAST_POS) ? '0 : bit_pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_error     <= 1'b0;
      irq           <= 1'b0;
      release_lines <= 1'b0;
      status        <= IDLE_CODE;
    end else begin
      bus_error <= err;
      if (err) begin
        irq           <= 1'b1;
        release_lines <= 1'b1;
        status        <= ERR_CODE;
      end else if (irq_clear) begin
        irq           <= 1'b0;
        release_lines <= 1'b0;
        status        <= IDLE_CODE;
      end
    end
  end

  assert_error_needs_involved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_error |-> $past(involved));

  assert_error_not_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_error |-> $past(bit_pos) != '0);

  assert_error_effects_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_error |-> (irq && release_lines && status == ERR_CODE));

  assert_error_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_error |=> !bus_error);

  assert_clear_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (status == IDLE_CODE && !release_lines));

  assert_status_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status == IDLE_CODE || status == ERR_CODE);

  assert_pos_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= LAST_POS);

endmodule

// File: tb/i2c_frame_guard_bench.sv
module i2c_frame_guard_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, involved = 1'b0, irq_clear = 1'b0;
  logic bus_error, release_lines, irq;
  logic [7:0] status;
  logic [3:0] bit_pos;
  int checks = 0, fails = 0, hi_cycles = 0;

  always #2 clk = ~clk;

  i2c_frame_guard u_i2c_frame_guard (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .involved(involved),
    .irq_clear(irq_clear), .bus_error(bus_error), .release_lines(release_lines),
    .irq(irq), .status(status), .bit_pos(bit_pos));

  always @(posedge clk) if (bus_error) hi_cycles <= hi_cycles + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(); repeat (8) @(negedge clk); endtask
  task automatic put(input logic c, input logic d); scl = c; sda = d; hold(); endtask
  task automatic do_start(); put(1'b0, 1'b1); put(1'b1, 1'b1); put(1'b1, 1'b0); endtask
  task automatic do_stop();  put(1'b0, 1'b0); put(1'b1, 1'b0); put(1'b1, 1'b1); endtask
  task automatic clock_bits(input int n, input logic [15:0] pat);
    for (int i = 0; i < n; i++) begin
      put(1'b0, pat[i]); put(1'b1, pat[i]); put(1'b0, pat[i]);
    end
  endtask
  task automatic clear_irq();
    irq_clear = 1'b1; @(negedge clk); irq_clear = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk(irq == 0 && release_lines == 0 && bus_error == 0, "R1 flags", {irq, release_lines, bus_error}, 0);
    chk(status == 8'hF8, "R1 status", status, 8'hF8);
    chk(bit_pos == 0, "R1 bit_pos", bit_pos, 0);
  endtask

  task automatic t_start_mid();
    int h0;
    involved = 1'b1;
    do_start();
    chk(irq == 0, "R5 start at boundary", irq, 0);
    clock_bits(3, 16'h0005);
    chk(bit_pos == 3, "R9 count after 3 clocks", bit_pos, 3);
    chk(irq == 0, "R10 data changes with SCL low", irq, 0);
    h0 = hi_cycles;
    put(1'b0, 1'b1); put(1'b1, 1'b1);
    sda = 1'b0;
    repeat (4) @(negedge clk);
    chk(irq == 1 && status == 8'h00, "R2 start mid byte", {irq, status}, 9'h100);
    chk(release_lines == 1, "R7 release", release_lines, 1);
    hold();
    chk(hi_cycles - h0 == 1, "R7 single strobe", hi_cycles - h0, 1);
    chk(bit_pos == 0, "R9 cleared by condition", bit_pos, 0);
  endtask

  task automatic t_clear();
    hold();
    chk(irq == 1 && release_lines == 1 && status == 8'h00, "R8 hold", {irq, release_lines, status}, 10'h300);
    clear_irq();
    chk(irq == 0 && release_lines == 0, "R8 cleared", {irq, release_lines}, 0);
    chk(status == 8'hF8, "R8 status F8", status, 8'hF8);
  endtask

  task automatic t_stop_mid();
    do_start();
    clock_bits(5, 16'h0012);
    chk(bit_pos == 5, "R9 count 5", bit_pos, 5);
    do_stop();
    chk(irq == 1 && status == 8'h00, "R3 stop mid byte", {irq, status}, 9'h100);
    clear_irq();
  endtask

  task automatic t_ack();
    do_start();
    clock_bits(8, 16'h00A5);
    chk(bit_pos == 8, "R4 in ack clock", bit_pos, 8);
    do_stop();
    chk(irq == 1 && status == 8'h00, "R4 stop in ack", {irq, status}, 9'h100);
    clear_irq();
  endtask

  task automatic t_legal();
    do_start();
    clock_bits(9, 16'h01C3);
    chk(bit_pos == 0, "R9 wrap after ack", bit_pos, 0);
    do_start();
    chk(irq == 0, "R5 repeated start after ack", irq, 0);
    clock_bits(9, 16'h0F0F);
    do_stop();
    chk(irq == 0 && status == 8'hF8, "R5 stop after ack", {irq, status}, 8'hF8);
  endtask

  task automatic t_not_involved();
    involved = 1'b0;
    do_start();
    clock_bits(4, 16'h0009);
    chk(bit_pos == 4, "R6 counts while uninvolved", bit_pos, 4);
    do_start();
    chk(irq == 0 && status == 8'hF8, "R6 no error uninvolved", {irq, status}, 8'hF8);
    chk(bit_pos == 0, "R6 start realigns count", bit_pos, 0);
    clock_bits(2, 16'h0001);
    do_stop();
    chk(irq == 0, "R6 stop uninvolved", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_mid();
    t_clear();
    t_stop_mid();
    t_ack();
    t_legal();
    t_not_involved();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule